// File: doc/BRIEF.md
# Power-of-Two Clock Prescaler with Glitch-Free Output Gating

This block takes a free-running master clock and produces one derived clock whose frequency is the master frequency divided by a power of two. A 4-bit division code selects the exponent. Two asynchronous control inputs are synchronised inside the block and act on the output only at safe points, so the output never shows a shortened pulse. The first control gates the output. The second is a deglitched power-down request that also stops the divider. After reset and after every wake-up, a startup hold-off of master cycles passes before the output may run.

When the output is inactive, an idle-mode bit decides how the pad behaves. Either the buffer stays on and drives a low level, or its enable is removed so that the pin floats. The block drives the clock value and the buffer enable separately, and the pad outside combines them.

Top module: `pow2_clk_gate`

## Requirements
- R1: For a division code c in 0..8, consecutive rising edges of `clk_out` are 2^c master cycles apart.
- R2: Any division code from 9 to 15 divides exactly as code 8 does, by 256.
- R3: After `rst` falls, `clk_out` stays low for at least 512 master cycles. It then starts toggling when `out_enable` is high.
- R4: For codes 1..8, `clk_out` is high for exactly half of each period. Code 0 passes the master clock through: the output is high while `clk` is high and low while `clk` is low.
- R5: The delay from `out_enable` rising to the first rising edge of `clk_out` is fixed for each code. Counting the first master rising edge after the change as edge 1, that rising edge of `clk_out` comes at edge 4 for code 0 and at edge 3 + 2^(c-1) for code c of 1 or more.
- R6: When `out_enable` falls, every high pulse already started on `clk_out` completes at full width. After that, the output stays low.
- R7: A `power_down` pulse shorter than 2·2^c + DEGLITCH_CYC master cycles is ignored, and `clk_out` keeps its period throughout the pulse.
- R8: A `power_down` level held longer than that threshold stops the output, leaving `clk_out` low.
- R9: `clk_out_oe` is 1 while the output is running. While the output is inactive, `clk_out_oe` follows `idle_drive_low` within two cycles: 1 means the low level is driven, and 0 means high impedance.
- R10: After `power_down` is released, `clk_out` stays low for at least 512 master cycles before it toggles again.
- R11: After the division code changes, the new period appears within one old output period plus the synchroniser delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running master clock |
| rst | input | 1 | Synchronous active-high reset |
| div_code | input | 4 | Division exponent code, values above 8 treated as 8 |
| out_enable | input | 1 | Asynchronous output gate, active high |
| power_down | input | 1 | Asynchronous power-down request, active high |
| idle_drive_low | input | 1 | Inactive-output mode: 1 drives low, 0 floats |
| clk_out | output | 1 | Divided and gated clock |
| clk_out_oe | output | 1 | Buffer enable for the output pad |

## Verification
The bench sweeps every legal code and two clamped codes, measuring the spacing of rising edges and the count of high samples. This separates errors in the exponent from errors in the duty cycle, and code 0 is also sampled in the low phase of the clock to confirm the pass-through. The output enable is raised at a fixed point and lowered at two different phases. This exposes any dependence of the start latency on phase and any truncated last pulse. Power-down is driven as a pulse below the deglitch threshold and as a long level, both modes of the idle bit are checked, and the wake-up and code-change cases check that the startup hold-off is honoured and that the output settles to the new ratio.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    PG_SLEEP = 2'd0,
    PG_WARM  = 2'd1,
    PG_RUN   = 2'd2
  } pg_state_e;
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pg_pd_filter.sv
module pg_pd_filter #(
  parameter int CODE_W       = 4,
  parameter int MAX_CODE     = 8,
  parameter int DEGLITCH_CYC = 1250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pd_s,
  input  logic [CODE_W-1:0] code_act,
  output logic              pd_hit
);
  localparam int THR_MAX = (2 << MAX_CODE) + DEGLITCH_CYC;
  localparam int TW      = $clog2(THR_MAX + 1);

  logic [TW-1:0] hold_cnt;
  logic [TW-1:0] thr;

  // two output periods plus the fixed deglitch span
  assign thr = (TW'(2) << code_act) + TW'(DEGLITCH_CYC);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
      pd_hit   <= 1'b0;
    end else if (!pd_s) begin
      hold_cnt <= '0;
      pd_hit   <= 1'b0;
    end else begin
      if (hold_cnt < thr) hold_cnt <= hold_cnt + 1'b1;
      pd_hit <= (hold_cnt >= thr - 1'b1);
    end
  end

  // R7: acceptance only ever follows a held request
  p_hit_after_hold_r7: assert property (@(posedge clk) disable iff (rst)
    pd_hit |-> $past(pd_s));
endmodule

// File: rtl/pg_divider.sv
module pg_divider #(
  parameter int CODE_W   = 4,
  parameter int MAX_CODE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              en_s,
  input  logic [CODE_W-1:0] code_req,
  output logic              gate_q,
  output logic              gate_next,
  output logic              boundary,
  output logic              div_q,
  output logic [CODE_W-1:0] code_act,
  output logic              clk_div
);
  localparam int CW = (MAX_CODE < 1) ? 1 : MAX_CODE;

  logic [CW-1:0]     cnt, cnt_nxt, last, half_nxt;
  logic [CW:0]       one_act, one_nxt;
  logic [CODE_W-1:0] code_nxt;
  logic              bit_nxt;
  logic              gate_neg, code0_neg;

  assign one_act  = (CW+1)'(1) << code_act;
  assign last     = one_act[CW-1:0] - 1'b1;
  assign boundary = (cnt == last);

  always_comb begin
    cnt_nxt   = cnt + 1'b1;
    gate_next = gate_q;
    code_nxt  = code_act;
    if (!run) begin
      cnt_nxt   = '0;
      gate_next = 1'b0;
      code_nxt  = code_req;
    end else if (!gate_q && en_s) begin
      // restart so the first edge has a fixed delay
      cnt_nxt   = '0;
      gate_next = 1'b1;
      code_nxt  = code_req;
    end else if (boundary) begin
      cnt_nxt   = '0;
      gate_next = en_s;
      code_nxt  = code_req;
    end
  end

  assign one_nxt  = (CW+1)'(1) << code_nxt;
  assign half_nxt = one_nxt[CW:1];
  assign bit_nxt  = |(cnt_nxt & half_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      gate_q   <= 1'b0;
      code_act <= '0;
      div_q    <= 1'b0;
    end else begin
      cnt      <= cnt_nxt;
      gate_q   <= gate_next;
      code_act <= code_nxt;
      div_q    <= gate_next & bit_nxt;
    end
  end

  // low-phase copies for the pass-through path
  always_ff @(negedge clk) begin
    if (rst) begin
      gate_neg  <= 1'b0;
      code0_neg <= 1'b0;
    end else begin
      gate_neg  <= gate_q;
      code0_neg <= (code_act == '0);
    end
  end

  assign clk_div = code0_neg ? (clk & gate_neg) : div_q;

  p_code_clamp_r2: assert property (@(posedge clk) disable iff (rst)
    code_act <= CODE_W'(MAX_CODE));

  p_gate_rise_restart_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q) |-> (cnt == '0));

  p_gate_fall_boundary_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_q) |-> ($past(boundary) || !$past(run)));
endmodule

// File: rtl/pow2_clk_gate.sv
module pow2_clk_gate
  import pg_pkg::*;
#(
  parameter int CODE_W       = 4,
  parameter int MAX_CODE     = 8,
  parameter int STARTUP_CYC  = 512,
  parameter int DEGLITCH_CYC = 1250,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] div_code,
  input  logic              out_enable,
  input  logic              power_down,
  input  logic              idle_drive_low,
  output logic              clk_out,
  output logic              clk_out_oe
);
  localparam int WW = $clog2(STARTUP_CYC);
  localparam int SW = CODE_W + 2;

  logic [SW-1:0]     sync_q;
  logic              en_s, pd_s;
  logic [CODE_W-1:0] code_s, code_req, code_act;
  logic              pd_hit, gate_q, gate_next, boundary, div_q, clk_div;
  logic              leave, run_div, oe_q;
  pg_state_e         state;
  logic [WW-1:0]     warm_cnt;

  pg_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({power_down, out_enable, div_code}),
    .q   (sync_q)
  );

  assign pd_s     = sync_q[SW-1];
  assign en_s     = sync_q[SW-2];
  assign code_s   = sync_q[CODE_W-1:0];
  assign code_req = (code_s > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code_s;

  pg_pd_filter #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE), .DEGLITCH_CYC(DEGLITCH_CYC)) u_pd (
    .clk      (clk),
    .rst      (rst),
    .pd_s     (pd_s),
    .code_act (code_act),
    .pd_hit   (pd_hit)
  );

  // leave the run state only where no pulse is cut short
  assign leave   = pd_hit & (boundary | ~gate_q);
  assign run_div = (state == PG_RUN) & ~leave;

  pg_divider #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_div (
    .clk       (clk),
    .rst       (rst),
    .run       (run_div),
    .en_s      (en_s),
    .code_req  (code_req),
    .gate_q    (gate_q),
    .gate_next (gate_next),
    .boundary  (boundary),
    .div_q     (div_q),
    .code_act  (code_act),
    .clk_div   (clk_div)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PG_WARM;
      warm_cnt <= '0;
    end else begin
      case (state)
        PG_WARM: begin
          if (pd_hit) begin
            state    <= PG_SLEEP;
            warm_cnt <= '0;
          end else if (warm_cnt == WW'(STARTUP_CYC - 1)) begin
            state <= PG_RUN;
          end else begin
            warm_cnt <= warm_cnt + 1'b1;
          end
        end
        PG_RUN: begin
          if (leave) state <= PG_SLEEP;
          warm_cnt <= '0;
        end
        default: begin
          warm_cnt <= '0;
          if (!pd_hit) state <= PG_WARM;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= gate_next | gate_q | idle_drive_low;
  end

  assign clk_out    = clk_div;
  assign clk_out_oe = oe_q;

  p_quiet_unless_run_r3: assert property (@(posedge clk) disable iff (rst)
    (state != PG_RUN) |-> (!div_q && !gate_q));

  p_warm_len_r3: assert property (@(posedge clk) disable iff (rst)
    (state == PG_RUN && $past(state) == PG_WARM) |-> ($past(warm_cnt) == WW'(STARTUP_CYC - 1)));

  p_oe_sleep_r9: assert property (@(posedge clk) disable iff (rst)
    (state == PG_SLEEP && $past(state) == PG_SLEEP) |-> (clk_out_oe == $past(idle_drive_low)));
endmodule

// File: tb/pow2_clk_gate_tb_top.sv
`timescale 1ns/1ps
module pow2_clk_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] div_code = 4'd1;
  logic       out_enable = 1'b1;
  logic       power_down = 1'b0;
  logic       idle_drive_low = 1'b0;
  logic       clk_out, clk_out_oe;
  int         n_chk = 0;
  int         n_err = 0;

  always #4 clk = ~clk;

  pow2_clk_gate dut_i (
    .clk            (clk),
    .rst            (rst),
    .div_code       (div_code),
    .out_enable     (out_enable),
    .power_down     (power_down),
    .idle_drive_low (idle_drive_low),
    .clk_out        (clk_out),
    .clk_out_oe     (clk_out_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic measure(input int n, output int highs, output int rises,
                         output int gmin, output int gmax);
    int   last_r;
    logic prev;
    highs = 0; rises = 0; gmin = 1 << 30; gmax = 0; last_r = -1;
    prev = clk_out;
    for (int i = 0; i < n; i++) begin
      tick();
      if (clk_out) highs++;
      if (clk_out && !prev) begin
        rises++;
        if (last_r >= 0) begin
          if (i - last_r < gmin) gmin = i - last_r;
          if (i - last_r > gmax) gmax = i - last_r;
        end
        last_r = i;
      end
      prev = clk_out;
    end
  endtask

  task automatic set_code(input logic [3:0] c);
    @(negedge clk); div_code = c;
  endtask

  task automatic test_startup();
    int k;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(clk_out == 1'b0, "R3 clk_out in reset", clk_out, 0);
    end
    chk(clk_out_oe == 1'b0, "R9 oe in reset", clk_out_oe, 0);
    @(negedge clk); rst = 1'b0;
    k = 0;
    for (int i = 1; i <= 700; i++) begin
      tick();
      if (clk_out) begin k = i; break; end
    end
    chk(k >= 512 && k <= 530, "R3 startup hold-off", k, 514);
  endtask

  task automatic test_ratios();
    int h, r, gmin, gmax;
    for (int x = 1; x <= 8; x++) begin
      set_code(4'(x));
      repeat (600) tick();
      measure(1024, h, r, gmin, gmax);
      chk(gmin == (1 << x) && gmax == (1 << x), "R1 rise spacing", gmax, 1 << x);
      chk(h == 512, "R4 duty half", h, 512);
    end
    chk(clk_out_oe == 1'b1, "R9 oe while running", clk_out_oe, 1);
    set_code(4'd0);
    repeat (600) tick();
    measure(64, h, r, gmin, gmax);
    chk(h == 64, "R1 R4 code0 high phase", h, 64);
    @(negedge clk); #1;
    chk(clk_out == 1'b0, "R4 code0 low phase", clk_out, 0);
  endtask

  task automatic test_clamp();
    int h, r, gmin, gmax;
    logic [3:0] codes [2] = '{4'd9, 4'd15};
    foreach (codes[j]) begin
      set_code(codes[j]);
      repeat (600) tick();
      measure(1024, h, r, gmin, gmax);
      chk(gmin == 256 && gmax == 256, "R2 clamped spacing", gmax, 256);
    end
  endtask

  task automatic test_enable_latency();
    int k, expk;
    int xs [3] = '{0, 1, 3};
    foreach (xs[j]) begin
      @(negedge clk); out_enable = 1'b0;
      set_code(4'(xs[j]));
      repeat (600) tick();
      @(negedge clk); out_enable = 1'b1;
      k = 0;
      for (int i = 1; i <= 600; i++) begin
        tick();
        if (clk_out) begin k = i; break; end
      end
      expk = (xs[j] == 0) ? 4 : 3 + (1 << (xs[j] - 1));
      chk(k == expk, "R5 enable latency", k, expk);
    end
  endtask

  task automatic test_disable();
    int   run_len, bad, lows;
    bit   partial;
    logic prev;
    int   offs [2] = '{1, 6};
    foreach (offs[j]) begin
      @(negedge clk); out_enable = 1'b1;
      set_code(4'd3);
      repeat (600 + offs[j]) tick();
      @(negedge clk); out_enable = 1'b0;
      prev = clk_out; partial = clk_out; run_len = 0; bad = 0; lows = 0;
      for (int i = 0; i < 60; i++) begin
        tick();
        if (clk_out) run_len++;
        if (!clk_out && prev) begin
          if (!partial && run_len != 4) bad = run_len;
          partial = 1'b0; run_len = 0;
        end
        if (i >= 40 && !clk_out) lows++;
        prev = clk_out;
      end
      chk(bad == 0, "R6 full last pulse", bad, 4);
      chk(lows == 20, "R6 low after disable", lows, 20);
    end
  endtask

  task automatic test_power_down();
    int h, r, gmin, gmax, k;
    @(negedge clk); out_enable = 1'b1; idle_drive_low = 1'b0;
    set_code(4'd1);
    repeat (600) tick();
    @(negedge clk); power_down = 1'b1;
    measure(600, h, r, gmin, gmax);
    chk(gmin == 2 && gmax == 2, "R7 short pulse ignored", gmax, 2);
    @(negedge clk); power_down = 1'b0;
    measure(100, h, r, gmin, gmax);
    chk(gmin == 2 && gmax == 2 && r > 40, "R7 running after pulse", r, 50);
    @(negedge clk); power_down = 1'b1;
    repeat (1400) tick();
    measure(50, h, r, gmin, gmax);
    chk(h == 0, "R8 output stopped", h, 0);
    chk(clk_out_oe == 1'b0, "R9 idle floats", clk_out_oe, 0);
    @(negedge clk); idle_drive_low = 1'b1;
    repeat (2) tick();
    chk(clk_out_oe == 1'b1 && clk_out == 1'b0, "R9 idle drives low", clk_out_oe, 1);
    @(negedge clk); idle_drive_low = 1'b0;
    repeat (2) tick();
    chk(clk_out_oe == 1'b0, "R9 idle floats again", clk_out_oe, 0);
    @(negedge clk); power_down = 1'b0;
    k = 0;
    for (int i = 1; i <= 700; i++) begin
      tick();
      if (clk_out) begin k = i; break; end
    end
    chk(k >= 512 && k <= 530, "R10 wake hold-off", k, 518);
  endtask

  task automatic test_settle();
    int h, r, gmin, gmax;
    set_code(4'd8);
    repeat (700) tick();
    set_code(4'd1);
    repeat (264) tick();
    measure(64, h, r, gmin, gmax);
    chk(gmin == 2 && gmax == 2, "R11 settle after change", gmax, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    test_startup();
    test_ratios();
    test_clamp();
    test_enable_latency();
    test_disable();
    test_power_down();
    test_settle();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule